// File: doc/BRIEF.md
# Stepped Soft-Start Reference Sequencer

This block orders the startup of a voltage-mode switching regulator. Nothing happens while the input supply is below its lockout level. Once the supply-good flag rises, the block enters a pre-start wait that lasts a fixed number of switching cycles. During that wait it asserts a flag that parks the error amplifier output just below the valley of the modulator ramp. The analog side also uses the wait to charge the bootstrap capacitor and to capture the current-limit setting.

After the wait, the block drives a step code to a reference DAC. The code climbs through 32 equal steps, and each step is held for a fixed count of switching cycles, so the reference rises as a staircase and not as a linear ramp. When the last step has been held for its full count, a done flag rises and stays high. A restart request sends the sequence back to the pre-start wait. A loss of supply-good returns it to idle at once.

All outputs are registered. Every input is sampled on the rising edge of the system clock. The switching tick is a one-clock pulse that marks each switching cycle.

Top module: `softstart_seq`

## Requirements
- R1: While uvloOk is sampled low, the cycle after shows refCode = 0, presetAmp = 0 and softDone = 0, and swTick pulses have no effect.
- R2: In idle, the first clock edge that samples uvloOk high enters the pre-start wait. From the next cycle presetAmp = 1 and refCode = 0.
- R3: The pre-start wait lasts PRESTART_CYCLES swTick pulses. presetAmp falls in the cycle after the last of these pulses is sampled, and presetAmp and softDone are never high together.
- R4: In the ramp phase refCode starts at 0 and rises by exactly 1 after every CYCLES_PER_STEP swTick pulses. It changes in no other way except to return to 0.
- R5: Once refCode = STEP_COUNT-1 (31 at default) has been held for CYCLES_PER_STEP pulses, softDone rises. softDone then stays high, with refCode held at STEP_COUNT-1, until a restart or a loss of uvloOk; later ticks change nothing.
- R6: With uvloOk high and the sequencer out of idle, a restartReq pulse returns it to the pre-start wait. refCode becomes 0, softDone becomes 0, and the wait's pulse count starts again from zero.
- R7: A restartReq sampled while uvloOk is low has no effect. The outputs stay at 0.
- R8: While rst_n is low, all outputs are 0 whatever the other inputs are.
- R9: When uvloOk is low and restartReq is high on the same edge, the return to idle takes precedence. presetAmp stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swTick | input | 1 | One-clock pulse per switching cycle |
| uvloOk | input | 1 | Input supply above lockout level |
| restartReq | input | 1 | Request to rerun the startup sequence |
| refCode | output | CODE_W (5) | Reference step code to the DAC |
| presetAmp | output | 1 | Park the error amplifier below the ramp valley |
| softDone | output | 1 | Staircase finished |

## Verification
The staircase is driven with tick bursts of several lengths. Bursts that stop one pulse short of a step or wait boundary are set against bursts that land exactly on it, so an off-by-one count in either counter shows up as the wrong code or the wrong phase. Long bursts check that the code climbs only one step per period and that it saturates at the top. Extra ticks after completion show that the done state holds. Restart pulses are applied in idle, in the wait, in the ramp and after completion, and a supply drop is applied on the same edge as a restart. Together these separate the correct priority and the correct counter clearing from a sequencer that merely resumes where it stopped.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_PRE  = 2'd1,
    SS_RAMP = 2'd2,
    SS_DONE = 2'd3
  } ssState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic clrCode;
    logic incCode;
  } ssStrobe_t;
endpackage

// File: rtl/softstart_dp.sv
module softstart_dp
  import softstart_pkg::*;
#(
  parameter int STEP_COUNT      = 32,
  parameter int CYCLES_PER_STEP = 32,
  parameter int PRESTART_CYCLES = 64,
  localparam int CODE_W = $clog2(STEP_COUNT),
  localparam int MAXC   = (PRESTART_CYCLES > CYCLES_PER_STEP) ? PRESTART_CYCLES : CYCLES_PER_STEP,
  localparam int CNT_W  = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssStrobe_t         strb,
  output logic              preLast,
  output logic              stepLast,
  output logic              codeMax,
  output logic [CODE_W-1:0] code
);
  logic [CNT_W-1:0] cnt;

  localparam logic [CNT_W-1:0]  PRE_LAST  = CNT_W'(PRESTART_CYCLES - 1);
  localparam logic [CNT_W-1:0]  STEP_LAST = CNT_W'(CYCLES_PER_STEP - 1);
  localparam logic [CODE_W-1:0] CODE_TOP  = CODE_W'(STEP_COUNT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strb.clrCnt) begin
      cnt <= '0;
    end else if (strb.incCnt) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (strb.clrCode) begin
      code <= '0;
    end else if (strb.incCode) begin
      code <= code + 1'b1;
    end
  end

  always_comb begin
    preLast  = (cnt == PRE_LAST);
    stepLast = (cnt == STEP_LAST);
    codeMax  = (code == CODE_TOP);
  end

  // R4
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (code == $past(code)) || (code == CODE_W'($past(code) + 1'b1)) || (code == '0));

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.incCode && !strb.clrCode) |=> $stable(code));

  // R5
  code_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.incCode && !strb.clrCode) |-> !codeMax);
endmodule

// File: rtl/softstart_ctrl.sv
module softstart_ctrl
  import softstart_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      swTick,
  input  logic      uvloOk,
  input  logic      restartReq,
  input  logic      preLast,
  input  logic      stepLast,
  input  logic      codeMax,
  output ssStrobe_t strb,
  output logic      presetAmp,
  output logic      softDone
);
  ssState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SS_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (!uvloOk) begin
      nextState    = SS_IDLE;
      strb.clrCnt  = 1'b1;
      strb.clrCode = 1'b1;
    end else if (restartReq && state != SS_IDLE) begin
      nextState    = SS_PRE;
      strb.clrCnt  = 1'b1;
      strb.clrCode = 1'b1;
    end else begin
      case (state)
        SS_IDLE: begin
          nextState    = SS_PRE;
          strb.clrCnt  = 1'b1;
          strb.clrCode = 1'b1;
        end
        SS_PRE: begin
          if (swTick) begin
            if (preLast) begin
              nextState    = SS_RAMP;
              strb.clrCnt  = 1'b1;
              strb.clrCode = 1'b1;
            end else begin
              strb.incCnt = 1'b1;
            end
          end
        end
        SS_RAMP: begin
          if (swTick) begin
            if (stepLast) begin
              strb.clrCnt = 1'b1;
              if (codeMax) nextState = SS_DONE;
              else         strb.incCode = 1'b1;
            end else begin
              strb.incCnt = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    presetAmp = (state == SS_PRE);
    softDone  = (state == SS_DONE);
  end

  // R1
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uvloOk |=> !presetAmp && !softDone);

  // R3
  exclusive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(presetAmp && softDone));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (softDone && uvloOk && !restartReq) |=> softDone);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uvloOk && restartReq && state != SS_IDLE) |=> presetAmp);
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int STEP_COUNT      = 32,
  parameter int CYCLES_PER_STEP = 32,
  parameter int PRESTART_CYCLES = 64,
  localparam int CODE_W = $clog2(STEP_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swTick,
  input  logic              uvloOk,
  input  logic              restartReq,
  output logic [CODE_W-1:0] refCode,
  output logic              presetAmp,
  output logic              softDone
);
  ssStrobe_t strb;
  logic preLast, stepLast, codeMax;

  softstart_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .swTick     (swTick),
    .uvloOk     (uvloOk),
    .restartReq (restartReq),
    .preLast    (preLast),
    .stepLast   (stepLast),
    .codeMax    (codeMax),
    .strb       (strb),
    .presetAmp  (presetAmp),
    .softDone   (softDone)
  );

  softstart_dp #(
    .STEP_COUNT      (STEP_COUNT),
    .CYCLES_PER_STEP (CYCLES_PER_STEP),
    .PRESTART_CYCLES (PRESTART_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .preLast  (preLast),
    .stepLast (stepLast),
    .codeMax  (codeMax),
    .code     (refCode)
  );

  // R5
  done_top_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softDone |-> (refCode == CODE_W'(STEP_COUNT - 1)));

  // R2
  preset_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presetAmp |-> (refCode == '0));
endmodule

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;
  localparam int PRE = 8;
  localparam int NV  = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swTick = 1'b0;
  logic uvloOk = 1'b0;
  logic restartReq = 1'b0;
  logic [4:0] refCode;
  logic presetAmp, softDone;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  softstart_seq #(.PRESTART_CYCLES(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .swTick(swTick), .uvloOk(uvloOk),
    .restartReq(restartReq), .refCode(refCode), .presetAmp(presetAmp),
    .softDone(softDone)
  );

  localparam int V_UVLO [NV] = '{0,1,1,1,1,1,1,1,1,1,1,1,1,1,0,0,1,1,1};
  localparam int V_RST  [NV] = '{0,0,0,0,0,0,0,0,0,0,0,1,0,0,0,1,0,1,0};
  localparam int V_TICK [NV] = '{5,0,7,1,31,1,928,32,31,1,50,0,8,40,0,3,5,7,1};
  localparam int V_CODE [NV] = '{0,0,0,0,0,1,30,31,31,31,31,0,0,1,0,0,0,0,0};
  localparam int V_PRE  [NV] = '{0,1,1,0,0,0,0,0,0,0,0,1,0,0,0,0,1,1,0};
  localparam int V_DONE [NV] = '{0,0,0,0,0,0,0,0,0,1,1,0,0,0,0,0,0,0,0};
  localparam string V_REQ [NV] = '{"R1","R2","R3","R3","R4","R4","R4","R4","R5",
                                    "R5","R5","R6","R6","R4","R1","R7","R2","R6","R6"};

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input int c, input int p, input int d);
    check(req, refCode, c, "refCode");
    check(req, presetAmp, p, "presetAmp");
    check(req, softDone, d, "softDone");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      swTick = 1'b1;
      @(negedge clk);
      swTick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: reset holds outputs low despite active inputs
    uvloOk = 1'b1;
    repeat (3) begin
      @(negedge clk);
      swTick = ~swTick;
    end
    swTick = 1'b0;
    @(negedge clk);
    checkAll("R8", 0, 0, 0);
    uvloOk = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      uvloOk = V_UVLO[v][0];
      if (V_RST[v] != 0) begin
        restartReq = 1'b1;
        @(negedge clk);
        restartReq = 1'b0;
      end else begin
        @(negedge clk);
      end
      ticks(V_TICK[v]);
      checkAll(V_REQ[v], V_CODE[v], V_PRE[v], V_DONE[v]);
    end

    // R9: supply loss and restart on the same edge, from the ramp phase
    ticks(40);
    uvloOk = 1'b0;
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    checkAll("R9", 0, 0, 0);

    // R1: supply loss during the pre-start wait
    uvloOk = 1'b1;
    @(negedge clk);
    ticks(3);
    checkAll("R2", 0, 1, 0);
    uvloOk = 1'b0;
    @(negedge clk);
    checkAll("R1", 0, 0, 0);

    // R6: restart after completion
    uvloOk = 1'b1;
    @(negedge clk);
    ticks(PRE + 32 * 32);
    checkAll("R5", 31, 0, 1);
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    checkAll("R6", 0, 1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule